// File: doc/BRIEF.md
# Successive-Approximation ADC Sequencer with Register Bank

This block is the digital front end of a four-channel successive-approximation converter. Software drives it through a 32-bit register bus with a single address. The registers hold a control word, a coded status word, latched interrupt flags with their enables, a channel-select mask and one result register per channel. A state machine brings the converter out of power-down and runs a timed calibration. It also runs one-shot scans over the selected channels and talks to the converter itself through a request/ready pair. Each 12-bit code that comes back lands in the result register of its channel.

The machine has six named states: `ST_PDN` (power-down, code 1), `ST_WAKE` (power-up wait, code 2), `ST_IDLE` (code 0), `ST_CAL` (calibrating, code 3), `ST_SAMP` (sampling, code 4) and `ST_CONV` (converting, code 6). Its transitions are:
- power-down request → `ST_PDN` from any state;
- request cleared: `ST_PDN` → `ST_WAKE`;
- wake timer expired: `ST_WAKE` → `ST_IDLE`;
- calibration start: `ST_IDLE` → `ST_CAL`;
- calibration timer expired: `ST_CAL` → `ST_IDLE`;
- conversion start: `ST_IDLE` → `ST_SAMP`;
- sample timer expired: `ST_SAMP` → `ST_CONV`;
- converter ready with channels left: `ST_CONV` → `ST_SAMP`;
- converter ready on the last channel: `ST_CONV` → `ST_IDLE`.

An interrupt line combines the latched flags with the enables.

Register map (byte offsets):

| Offset | Contents |
|---|---|
| 0x000 | Control: bit 0 power-down, bit 8 clock source, bit 14 calibrate, bit 24 start, bit 29 mode |
| 0x004 | Status: [2:0] state code, bit 29 calibration busy, bit 30 calibration failed |
| 0x010 | Interrupt flags: bit 0 end of chain, bit 1 end of conversion |
| 0x020 | Interrupt enables [3:0] |
| 0x024 | Per-channel enables [3:0] |
| 0x094 | Timing word |
| 0x0A4 | Channel-select mask [3:0] |
| 0x100 + 4·n | Result of channel n |

Top module: `sar_adc_ctrl`

## Requirements
- R1: After reset the state is `ST_PDN`. Control reads 0x0000_0001, status reads 0x0000_0001, the interrupt flags read 0 and `irq` is low.
- R2: Control bit 0 is a level power-down request. While it is set, the state becomes `ST_PDN` on the next cycle, from any state, and an ongoing scan or calibration is abandoned. Once it is cleared, the state spends exactly WAKE_CYCLES cycles in `ST_WAKE` (status code 2) and then enters `ST_IDLE` (code 0).
- R3: Writing 1 to control bit 14 in `ST_IDLE` enters `ST_CAL`. Status then reads code 3 with bit 29 set for exactly CAL_CYCLES cycles, and afterwards returns to `ST_IDLE`. Bits 14 and 24 always read back 0.
- R4: At the end of a calibration the `cal_fail_in` input is captured into status bit 30. The bit is cleared when the next calibration starts.
- R5: Writing 1 to control bit 24 in `ST_IDLE` with a nonzero channel-select mask (offset 0x0A4, bits [3:0]) starts a one-shot scan. The mask is captured at start. The selected channels are visited in ascending order. Each spends SAMPLE_CYCLES cycles in `ST_SAMP` and then waits in `ST_CONV`, with `conv_req` high and `conv_chan` steady, until `conv_ready`.
- R6: The code returned with `conv_ready` is stored in bits [11:0] of the result register at 0x100 + 4·n for channel n. Result registers of channels that were not scanned keep their values.
- R7: Every completed conversion sets flag bit 1. The last conversion of a scan also sets flag bit 0, and the machine returns to `ST_IDLE`.
- R8: Writing 1 to a flag bit clears it and writing 0 leaves it unchanged. A set event in the same cycle as a clear wins.
- R9: `irq` is high when flag bit 0 and enable bit 0 are both set. It is also high when flag bit 1 and enable bit 1 are both set and some channel that completed a conversion since flag bit 1 was last cleared has its per-channel enable set. Otherwise `irq` is low.
- R10: Start commands are ignored outside `ST_IDLE`, and a conversion start with an all-zero mask is ignored. When both start bits are written together, calibration takes precedence and no scan runs.
- R11: Control bits 8 and 29, the interrupt enables [3:0], the per-channel enables [3:0] and the 32-bit timing word read back as written. Every scan is one-shot whatever the value of bit 29.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the addressed register |
| bus_addr | input | 12 | Byte address for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| conv_req | output | 1 | Conversion request to the converter |
| conv_chan | output | 2 | Channel being converted |
| conv_ready | input | 1 | Converter presents a finished code |
| conv_code | input | 12 | Converted code, valid with conv_ready |
| cal_fail_in | input | 1 | Calibration verdict from the converter |
| irq | output | 1 | Interrupt request |

## Verification
The bench sweeps all fifteen nonzero channel masks. For each mask it checks the visiting order, the codes stored per channel, and that unscanned channels keep their results. A design that scanned in descending order or read the live mask would log the wrong channel sequence. A design that wrote results through a wrong channel index would corrupt a neighbour's register. The state timing is counted to the exact cycle on the power-up wait, on calibration and on the sample phase, so an off-by-one counter shows up as a wrong status code. The bench also probes the rules around ignored commands: starting during power-down, starting during a scan, writing the mask mid-scan, an empty mask, and both start bits written together. It exercises the interrupt gating by enable and per-channel enable, and write-0 to the flags. Finally it aborts a scan by power-down and checks that no flag was raised.

// File: rtl/sar_adc_pkg.sv
package sar_adc_pkg;

    // Status codes; the encoding is visible to software in status [2:0]
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_PDN  = 3'd1,
        ST_WAKE = 3'd2,
        ST_CAL  = 3'd3,
        ST_SAMP = 3'd4,
        ST_CONV = 3'd6
    } sar_state_e;

    localparam int OFS_CTRL   = 'h000;
    localparam int OFS_STAT   = 'h004;
    localparam int OFS_FLAGS  = 'h010;
    localparam int OFS_IEN    = 'h020;
    localparam int OFS_CHIEN  = 'h024;
    localparam int OFS_TIMING = 'h094;
    localparam int OFS_CHSEL  = 'h0A4;
    localparam int OFS_DATA   = 'h100;

    localparam int B_PDN     = 0;
    localparam int B_CLKSRC  = 8;
    localparam int B_CALGO   = 14;
    localparam int B_CONVGO  = 24;
    localparam int B_MODE    = 29;
    localparam int B_CALBUSY = 29;
    localparam int B_CALFAIL = 30;

    localparam int F_CHAIN = 0;
    localparam int F_CONV  = 1;

endpackage

// File: rtl/sar_adc_fsm.sv
module sar_adc_fsm
    import sar_adc_pkg::*;
#(
    parameter int NCH           = 4,
    parameter int WAKE_CYCLES   = 4,
    parameter int CAL_CYCLES    = 40,
    parameter int SAMPLE_CYCLES = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    pdn_req,
    input  logic                    cal_go,
    input  logic                    conv_go,
    input  logic [NCH-1:0]          chan_mask,
    input  logic                    conv_ready,
    input  logic                    cal_fail_in,
    output sar_state_e              state,
    output logic                    conv_req,
    output logic [$clog2(NCH)-1:0]  conv_chan,
    output logic                    eoc_pulse,
    output logic                    ech_pulse,
    output logic                    cal_fail
);
    localparam int CH_W  = $clog2(NCH);
    localparam int CMAX0 = (WAKE_CYCLES > CAL_CYCLES) ? WAKE_CYCLES : CAL_CYCLES;
    localparam int CMAX  = (CMAX0 > SAMPLE_CYCLES) ? CMAX0 : SAMPLE_CYCLES;
    localparam int CNT_W = $clog2(CMAX + 1);

    sar_state_e       nxt;
    logic [CNT_W-1:0] cnt, cnt_n;
    logic [NCH-1:0]   pending, pend_n, sel_oh;
    logic [CH_W-1:0]  sel;
    logic             cal_launch, cal_finish;

    // lowest pending channel
    always_comb begin
        sel = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (pending[i]) sel = CH_W'(i);
        end
        sel_oh = NCH'(1) << sel;
    end

    // next-state logic
    always_comb begin
        nxt        = state;
        cnt_n      = cnt + CNT_W'(1);
        pend_n     = pending;
        cal_launch = 1'b0;
        cal_finish = 1'b0;
        if (pdn_req) begin
            nxt   = ST_PDN;
            cnt_n = '0;
        end else begin
            unique case (state)
                ST_PDN: begin
                    nxt   = ST_WAKE;
                    cnt_n = '0;
                end
                ST_WAKE: begin
                    if (cnt == CNT_W'(WAKE_CYCLES - 1)) begin
                        nxt   = ST_IDLE;
                        cnt_n = '0;
                    end
                end
                ST_IDLE: begin
                    cnt_n = '0;
                    if (cal_go) begin
                        nxt        = ST_CAL;
                        cal_launch = 1'b1;
                    end else if (conv_go && (chan_mask != '0)) begin
                        nxt    = ST_SAMP;
                        pend_n = chan_mask;
                    end
                end
                ST_CAL: begin
                    if (cnt == CNT_W'(CAL_CYCLES - 1)) begin
                        nxt        = ST_IDLE;
                        cnt_n      = '0;
                        cal_finish = 1'b1;
                    end
                end
                ST_SAMP: begin
                    if (cnt == CNT_W'(SAMPLE_CYCLES - 1)) begin
                        nxt   = ST_CONV;
                        cnt_n = '0;
                    end
                end
                ST_CONV: begin
                    cnt_n = '0;
                    if (conv_ready) begin
                        pend_n = pending & ~sel_oh;
                        nxt    = (pend_n == '0) ? ST_IDLE : ST_SAMP;
                    end
                end
                default: begin
                    nxt   = ST_PDN;
                    cnt_n = '0;
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_PDN;
            cnt      <= '0;
            pending  <= '0;
            cal_fail <= 1'b0;
        end else begin
            state   <= nxt;
            cnt     <= cnt_n;
            pending <= pend_n;
            if (cal_launch)      cal_fail <= 1'b0;
            else if (cal_finish) cal_fail <= cal_fail_in;
        end
    end

    // outputs
    always_comb begin
        conv_req  = (state == ST_CONV);
        conv_chan = sel;
        eoc_pulse = (state == ST_CONV) && conv_ready && !pdn_req;
        ech_pulse = eoc_pulse && ((pending & ~sel_oh) == '0);
    end

    // R2
    pdn_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pdn_req |=> state == ST_PDN);

    // R5
    chan_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_req && !conv_ready && !pdn_req) |=> (conv_req && $stable(conv_chan)));

    // R10
    busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CAL && !pdn_req && conv_go) |=> (state == ST_CAL || state == ST_IDLE));

    // R7
    chain_end_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ech_pulse |=> state == ST_IDLE);

endmodule

// File: rtl/sar_adc_irq.sv
module sar_adc_irq #(
    parameter int NCH = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    eoc_set,
    input  logic [$clog2(NCH)-1:0]  eoc_chan,
    input  logic                    ech_set,
    input  logic                    clr_wr,
    input  logic [1:0]              clr_bits,
    input  logic [NCH-1:0]          chan_en,
    input  logic [1:0]              ien,
    output logic [1:0]              flags,
    output logic                    irq
);
    logic [NCH-1:0] ch_done;
    logic           clr_chain, clr_conv;

    assign clr_chain = clr_wr && clr_bits[0];
    assign clr_conv  = clr_wr && clr_bits[1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags <= 2'b00;
        end else begin
            flags[0] <= (flags[0] && !clr_chain) || ech_set;
            flags[1] <= (flags[1] && !clr_conv)  || eoc_set;
        end
    end

    // per-channel record of completions behind the conversion flag
    for (genvar g = 0; g < NCH; g++) begin : g_chdone
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ch_done[g] <= 1'b0;
            end else begin
                ch_done[g] <= (ch_done[g] && !clr_conv) ||
                              (eoc_set && (eoc_chan == $clog2(NCH)'(g)));
            end
        end
    end

    assign irq = (flags[0] && ien[0]) ||
                 (flags[1] && ien[1] && ((ch_done & chan_en) != '0));

    // R8
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eoc_set |=> flags[1]);

    // R9
    quiet_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flags == 2'b00) |-> !irq);

endmodule

// File: rtl/sar_adc_ctrl.sv
module sar_adc_ctrl
    import sar_adc_pkg::*;
#(
    parameter int NCH           = 4,
    parameter int CODE_W        = 12,
    parameter int ADDR_W        = 12,
    parameter int WAKE_CYCLES   = 4,
    parameter int CAL_CYCLES    = 40,
    parameter int SAMPLE_CYCLES = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bus_wr,
    input  logic [ADDR_W-1:0]       bus_addr,
    input  logic [31:0]             bus_wdata,
    output logic [31:0]             bus_rdata,
    output logic                    conv_req,
    output logic [$clog2(NCH)-1:0]  conv_chan,
    input  logic                    conv_ready,
    input  logic [CODE_W-1:0]       conv_code,
    input  logic                    cal_fail_in,
    output logic                    irq
);
    localparam int CH_W = $clog2(NCH);

    sar_state_e      state;
    logic            ctl_pdn, ctl_clksrc, ctl_mode;
    logic [3:0]      ien;
    logic [NCH-1:0]  chan_en, chan_mask;
    logic [31:0]     timing;
    logic [CODE_W-1:0] result [NCH];
    logic            wr_ctrl, wr_flags;
    logic            cal_go, conv_go;
    logic            eoc_pulse, ech_pulse, cal_fail;
    logic [1:0]      flags;

    assign wr_ctrl  = bus_wr && (bus_addr == ADDR_W'(OFS_CTRL));
    assign wr_flags = bus_wr && (bus_addr == ADDR_W'(OFS_FLAGS));
    assign cal_go   = wr_ctrl && bus_wdata[B_CALGO];
    assign conv_go  = wr_ctrl && bus_wdata[B_CONVGO];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_pdn    <= 1'b1;
            ctl_clksrc <= 1'b0;
            ctl_mode   <= 1'b0;
            ien        <= '0;
            chan_en    <= '0;
            chan_mask  <= '0;
            timing     <= '0;
        end else if (bus_wr) begin
            if (bus_addr == ADDR_W'(OFS_CTRL)) begin
                ctl_pdn    <= bus_wdata[B_PDN];
                ctl_clksrc <= bus_wdata[B_CLKSRC];
                ctl_mode   <= bus_wdata[B_MODE];
            end
            if (bus_addr == ADDR_W'(OFS_IEN))    ien       <= bus_wdata[3:0];
            if (bus_addr == ADDR_W'(OFS_CHIEN))  chan_en   <= bus_wdata[NCH-1:0];
            if (bus_addr == ADDR_W'(OFS_CHSEL))  chan_mask <= bus_wdata[NCH-1:0];
            if (bus_addr == ADDR_W'(OFS_TIMING)) timing    <= bus_wdata;
        end
    end

    sar_adc_fsm #(
        .NCH           (NCH),
        .WAKE_CYCLES   (WAKE_CYCLES),
        .CAL_CYCLES    (CAL_CYCLES),
        .SAMPLE_CYCLES (SAMPLE_CYCLES)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .pdn_req     (ctl_pdn),
        .cal_go      (cal_go),
        .conv_go     (conv_go),
        .chan_mask   (chan_mask),
        .conv_ready  (conv_ready),
        .cal_fail_in (cal_fail_in),
        .state       (state),
        .conv_req    (conv_req),
        .conv_chan   (conv_chan),
        .eoc_pulse   (eoc_pulse),
        .ech_pulse   (ech_pulse),
        .cal_fail    (cal_fail)
    );

    sar_adc_irq #(
        .NCH (NCH)
    ) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .eoc_set  (eoc_pulse),
        .eoc_chan (conv_chan),
        .ech_set  (ech_pulse),
        .clr_wr   (wr_flags),
        .clr_bits (bus_wdata[1:0]),
        .chan_en  (chan_en),
        .ien      (ien[1:0]),
        .flags    (flags),
        .irq      (irq)
    );

    // per-channel result registers
    for (genvar g = 0; g < NCH; g++) begin : g_res
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                result[g] <= '0;
            end else if (eoc_pulse && (conv_chan == CH_W'(g))) begin
                result[g] <= conv_code;
            end
        end
    end

    // read mux
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADDR_W'(OFS_CTRL): begin
                bus_rdata[B_PDN]    = ctl_pdn;
                bus_rdata[B_CLKSRC] = ctl_clksrc;
                bus_rdata[B_MODE]   = ctl_mode;
            end
            ADDR_W'(OFS_STAT): begin
                bus_rdata[2:0]       = state;
                bus_rdata[B_CALBUSY] = (state == ST_CAL);
                bus_rdata[B_CALFAIL] = cal_fail;
            end
            ADDR_W'(OFS_FLAGS):  bus_rdata[1:0]     = flags;
            ADDR_W'(OFS_IEN):    bus_rdata[3:0]     = ien;
            ADDR_W'(OFS_CHIEN):  bus_rdata[NCH-1:0] = chan_en;
            ADDR_W'(OFS_CHSEL):  bus_rdata[NCH-1:0] = chan_mask;
            ADDR_W'(OFS_TIMING): bus_rdata          = timing;
            default: begin
                for (int i = 0; i < NCH; i++) begin
                    if (bus_addr == ADDR_W'(OFS_DATA + 4 * i))
                        bus_rdata[CODE_W-1:0] = result[i];
                end
            end
        endcase
    end

    // R6
    result_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eoc_pulse |=> result[$past(conv_chan)] == $past(conv_code));

endmodule

// File: tb/sar_adc_ctrl_tb.sv
module sar_adc_ctrl_tb;
    localparam int WAKE = 4;
    localparam int CALN = 40;
    localparam int SAMP = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        conv_req;
    logic [1:0]  conv_chan;
    logic        conv_ready = 1'b0;
    logic [11:0] conv_code = '0;
    logic        cal_fail_in = 1'b0;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    // converter stub bookkeeping
    logic [11:0] exp_res [4] = '{default: 12'h000};
    int          chan_log [64];
    int          log_n = 0;
    int          seq = 0;
    int          stub_wait = 0;

    always #5 clk = ~clk;

    sar_adc_ctrl #(
        .WAKE_CYCLES   (WAKE),
        .CAL_CYCLES    (CALN),
        .SAMPLE_CYCLES (SAMP)
    ) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_wr      (bus_wr),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .conv_req    (conv_req),
        .conv_chan   (conv_chan),
        .conv_ready  (conv_ready),
        .conv_code   (conv_code),
        .cal_fail_in (cal_fail_in),
        .irq         (irq)
    );

    // converter stub: answers on the third cycle of a request
    always @(negedge clk) begin
        if (conv_ready) begin
            conv_ready = 1'b0;
        end else if (conv_req) begin
            if (stub_wait == 2) begin
                stub_wait = 0;
                conv_code = 12'(((int'(conv_chan) * 997) + (seq * 61)) ^ 'hA5A);
                exp_res[conv_chan] = conv_code;
                if (log_n < 64) chan_log[log_n] = int'(conv_chan);
                log_n = log_n + 1;
                seq = seq + 1;
                conv_ready = 1'b1;
            end else begin
                stub_wait = stub_wait + 1;
            end
        end else begin
            stub_wait = 0;
        end
    end

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        bus_addr  = 12'(a);
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        bus_addr = 12'(a);
        #1;
        d = bus_rdata;
    endtask

    task automatic rd_chk(input string req, input int a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        check(req, v, exp);
    endtask

    task automatic wait_idle();
        logic [31:0] v;
        for (int i = 0; i < 400; i++) begin
            rd('h004, v);
            if (v[2:0] == 3'd0) return;
            @(negedge clk);
        end
        check("R7 idle timeout", v, 32'h0);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: got hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd_chk("R1 ctrl", 'h000, 32'h1);
        rd_chk("R1 status", 'h004, 32'h1);
        rd_chk("R1 flags", 'h010, 32'h0);
        check("R1 irq", {31'b0, irq}, 32'h0);

        // R10 start during power-down ignored
        wr('h0A4, 32'hF);
        wr('h000, 32'h0100_0001);
        repeat (SAMP + 1) @(negedge clk);
        rd_chk("R10 start in pdn", 'h004, 32'h1);
        rd_chk("R10 no flags", 'h010, 32'h0);

        // R2 wake timing
        wr('h000, 32'h0);
        rd_chk("R2 still pdn", 'h004, 32'h1);
        @(negedge clk);
        rd_chk("R2 wake first", 'h004, 32'h2);
        repeat (WAKE - 1) @(negedge clk);
        rd_chk("R2 wake last", 'h004, 32'h2);
        @(negedge clk);
        rd_chk("R2 idle", 'h004, 32'h0);

        // R11 readback
        wr('h020, 32'hF);
        wr('h024, 32'hA);
        wr('h094, 32'hDEAD_BEEF);
        wr('h000, 32'h2000_0100);
        rd_chk("R11 ctrl", 'h000, 32'h2000_0100);
        rd_chk("R11 ien", 'h020, 32'hF);
        rd_chk("R11 chien", 'h024, 32'hA);
        rd_chk("R11 timing", 'h094, 32'hDEAD_BEEF);

        // R3 calibration pass, bit 14 self-clearing
        cal_fail_in = 1'b0;
        wr('h000, 32'h0000_4000);
        rd_chk("R3 ctrl reads 0", 'h000, 32'h0);
        rd_chk("R3 busy", 'h004, 32'h2000_0003);
        repeat (CALN - 1) @(negedge clk);
        rd_chk("R3 busy last", 'h004, 32'h2000_0003);
        @(negedge clk);
        rd_chk("R3 done", 'h004, 32'h0);

        // R4 failing calibration
        cal_fail_in = 1'b1;
        wr('h000, 32'h0000_4000);
        repeat (CALN) @(negedge clk);
        rd_chk("R4 fail latched", 'h004, 32'h4000_0000);

        // R4 fail clears on next start; R10 cal beats conv
        cal_fail_in = 1'b0;
        wr('h0A4, 32'hF);
        wr('h000, 32'h0100_4000);
        rd_chk("R4 fail cleared", 'h004, 32'h2000_0003);
        repeat (CALN) @(negedge clk);
        rd_chk("R10 cal wins status", 'h004, 32'h0);
        rd_chk("R10 cal wins flags", 'h010, 32'h0);

        // R10 empty mask
        wr('h0A4, 32'h0);
        wr('h000, 32'h0100_0000);
        rd_chk("R10 empty mask", 'h004, 32'h0);

        // R5..R9 sweep over every nonzero mask
        for (int m = 1; m < 16; m++) begin
            int base;
            int idx;
            int low;
            base = log_n;
            low = 0;
            for (int c = 3; c >= 0; c--) if (m[c]) low = c;
            wr('h0A4, 32'(m));
            wr('h020, 32'h3);
            wr('h024, 32'hF);
            wr('h000, 32'h0100_0000);
            rd_chk("R5 sample", 'h004, 32'h4);
            repeat (SAMP - 1) @(negedge clk);
            rd_chk("R5 sample last", 'h004, 32'h4);
            @(negedge clk);
            rd_chk("R5 convert", 'h004, 32'h6);
            check("R5 first chan", {30'b0, conv_chan}, 32'(low));
            if (m[0]) begin
                wr('h000, 32'h0100_0000);
                wr('h0A4, 32'h0);
            end
            wait_idle();
            check("R10 conv count", 32'(log_n - base), 32'($countones(4'(m))));
            idx = base;
            for (int c = 0; c < 4; c++) begin
                if (m[c]) begin
                    check("R5 order", 32'(chan_log[idx]), 32'(c));
                    idx++;
                end
            end
            for (int c = 0; c < 4; c++)
                rd_chk("R6 result", 'h100 + 4 * c, {20'b0, exp_res[c]});
            rd_chk("R7 flags", 'h010, 32'h3);
            check("R9 irq both", {31'b0, irq}, 32'h1);
            wr('h010, 32'h0);
            rd_chk("R8 write zero", 'h010, 32'h3);
            wr('h010, 32'h1);
            rd_chk("R8 clear chain", 'h010, 32'h2);
            check("R9 irq conv", {31'b0, irq}, 32'h1);
            wr('h020, 32'h1);
            check("R9 conv disabled", {31'b0, irq}, 32'h0);
            wr('h020, 32'h2);
            wr('h024, 32'(~m & 'hF));
            check("R9 chan disabled", {31'b0, irq}, 32'h0);
            wr('h024, 32'(m & -m));
            check("R9 chan enabled", {31'b0, irq}, 32'h1);
            wr('h010, 32'h2);
            rd_chk("R8 clear conv", 'h010, 32'h0);
            check("R9 irq off", {31'b0, irq}, 32'h0);
        end

        // R2 power-down aborts a scan
        wr('h0A4, 32'hF);
        wr('h000, 32'h0100_0000);
        wr('h000, 32'h1);
        @(negedge clk);
        rd_chk("R2 abort pdn", 'h004, 32'h1);
        check("R2 abort req", {31'b0, conv_req}, 32'h0);
        wr('h000, 32'h0);
        wait_idle();
        rd_chk("R2 abort no flags", 'h010, 32'h0);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule